// File: doc/BRIEF.md
# Interlaced Field Parity Stream Aligner

This block joins a pixel stream carrying interlaced video to a native video output whose timing comes from an external generator. The stream marks the first pixel of each field with a start-of-frame flag on `s_tuser`, marks line ends on `s_tlast`, and carries a one-bit field parity on `s_fid`. The generator supplies an active-video strobe, a vertical-blank strobe and its own field parity. The block takes the parity of each stream field from its start-of-frame beat and compares it with the generator's parity at the first active cycle of each generator field. It releases the stream only when the two agree, so odd and even fields are never swapped on the output.

While it waits, the block stalls the stream. Once a field is released, it takes one pixel on every active-video cycle. A stream field whose parity disagrees is discarded up to the next start-of-frame, and the next generator field is tried again. The stream parity can be delayed by a fixed number of fields to make up for processing stages that hold whole fields. A lock flag tells the system when output has been aligned for consecutive fields.

Top module: `field_lock_aligner`

## Requirements
- R1: In a released field, each active-video cycle takes one stream pixel in order, and `vo_data` shows it one clock later. `vo_eol` repeats `s_tlast` of that pixel.
- R2: The stream parity is taken only from the beat that has `s_tuser` high. Changes of `s_fid` on other beats have no effect on any output.
- R3: A generator field starts on the first cycle with `vt_active` high after a cycle with `vt_vblank` high. A stream field is released only if its compare parity equals `vt_fid` on that cycle. Otherwise no pixel of it reaches `vo_data`.
- R4: With `FID_DELAY` = D, the compare parity is the `s_fid` of the start-of-frame beat D fields earlier (0 before D fields have passed). D = 0 uses the current start-of-frame beat.
- R5: While a start-of-frame beat is offered and the cycle is not a generator field start, `s_tready` is low.
- R6: On a parity mismatch, `mismatch` is high for exactly one clock, one clock after the field start. The stream field is dropped through to its last beat, and the following generator field is tried with the next stream field.
- R7: `locked` rises one clock after the `LOCK_FIELDS`-th consecutive aligned field start (default 2). A mismatch returns the count to zero.
- R8: An active-video cycle that delivers no pixel (underflow) clears `locked` on the next clock.
- R9: `vo_data` is zero whenever `vo_active` is low. `vo_active` and `vo_fid` are `vt_active` and `vt_fid` delayed by one clock.
- R10: After reset, all outputs are low and the block waits for a start-of-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | DATA_W | Stream pixel |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat accepted |
| s_tuser | input | 1 | Start-of-frame (first pixel of a field) |
| s_tlast | input | 1 | Last pixel of a line |
| s_fid | input | 1 | Stream field parity |
| vt_active | input | 1 | Generator active-video strobe |
| vt_vblank | input | 1 | Generator vertical blank |
| vt_fid | input | 1 | Generator field parity |
| vo_data | output | DATA_W | Output pixel, zero outside active video |
| vo_active | output | 1 | Delayed active-video strobe |
| vo_eol | output | 1 | Output pixel ends a line |
| vo_fid | output | 1 | Delayed generator parity |
| locked | output | 1 | Aligned for consecutive fields |
| mismatch | output | 1 | One-clock pulse on a parity mismatch |

## Verification
The hardest case to reach from the ports is a lock that builds, breaks on a mismatch, rebuilds, and then breaks on an underflow in the middle of a released field. Stream parities come from a seeded random draw, so mismatches fall at varied points. A few fields at the start and at the end are forced so that lock is reached early, lost on a mismatch, and held going into the final field. In that field, `s_tvalid` is dropped for a single active cycle. Non-start beats carry random parity throughout, so any sampling outside start-of-frame would show up as a wrong release decision.

// File: rtl/fla_pkg.sv
package fla_pkg;

    typedef enum logic [1:0] {
        FLA_SEEK  = 2'd0,
        FLA_ARMED = 2'd1,
        FLA_RUN   = 2'd2
    } fla_state_e;

    typedef struct packed {
        logic take;
        logic aligned;
        logic mism;
        logic uflow;
        logic lost;
    } fla_evt_t;

    function automatic logic sof_at_head(input logic valid, input logic user);
        return valid && user;
    endfunction

endpackage

// File: rtl/fla_field_tracker.sv
module fla_field_tracker (
    input  logic clk,
    input  logic rst,
    input  logic vt_active,
    input  logic vt_vblank,
    output logic field_start
);
    logic blank_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_seen <= 1'b0;
        end else if (vt_vblank) begin
            blank_seen <= 1'b1;
        end else if (vt_active) begin
            blank_seen <= 1'b0;
        end
    end

    assign field_start = vt_active && blank_seen;
endmodule

// File: rtl/fla_fid_delay.sv
module fla_fid_delay #(
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic fid_in,
    input  logic shift,
    output logic fid_cand
);
    logic [DEPTH-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist[0] <= 1'b0;
        end else if (shift) begin
            hist[0] <= fid_in;
        end
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                hist[i] <= 1'b0;
            end else if (shift) begin
                hist[i] <= hist[i-1];
            end
        end
    end

    assign fid_cand = hist[DEPTH-1];
endmodule

// File: rtl/fla_align_ctrl.sv
module fla_align_ctrl
    import fla_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     s_tvalid,
    input  logic     s_tuser,
    input  logic     vt_active,
    input  logic     field_start,
    input  logic     fid_match,
    output logic     s_tready,
    output fla_evt_t evt
);
    fla_state_e state, state_nxt;
    logic       head_sof;

    always_comb begin
        head_sof  = sof_at_head(s_tvalid, s_tuser);
        state_nxt = state;
        s_tready  = 1'b0;
        evt       = '0;
        unique case (state)
            FLA_SEEK: begin
                // discard beats until a start-of-frame is at the head
                s_tready = s_tvalid && !s_tuser;
                if (head_sof) begin
                    state_nxt = FLA_ARMED;
                end
            end
            FLA_ARMED, FLA_RUN: begin
                if (field_start) begin
                    if (!head_sof) begin
                        evt.lost  = 1'b1;
                        state_nxt = FLA_SEEK;
                    end else if (fid_match) begin
                        s_tready    = 1'b1;
                        evt.take    = 1'b1;
                        evt.aligned = 1'b1;
                        state_nxt   = FLA_RUN;
                    end else begin
                        s_tready  = 1'b1;
                        evt.mism  = 1'b1;
                        state_nxt = FLA_SEEK;
                    end
                end else if (state == FLA_ARMED) begin
                    evt.uflow = vt_active;
                end else if (head_sof) begin
                    state_nxt = FLA_ARMED;
                    evt.uflow = vt_active;
                end else begin
                    s_tready  = vt_active;
                    evt.take  = vt_active && s_tvalid;
                    evt.uflow = vt_active && !s_tvalid;
                end
            end
            default: state_nxt = FLA_SEEK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FLA_SEEK;
        end else begin
            state <= state_nxt;
        end
    end
endmodule

// File: rtl/field_lock_aligner.sv
module field_lock_aligner
    import fla_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int FID_DELAY   = 0,
    parameter int LOCK_FIELDS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic              s_tuser,
    input  logic              s_tlast,
    input  logic              s_fid,
    input  logic              vt_active,
    input  logic              vt_vblank,
    input  logic              vt_fid,
    output logic [DATA_W-1:0] vo_data,
    output logic              vo_active,
    output logic              vo_eol,
    output logic              vo_fid,
    output logic              locked,
    output logic              mismatch
);
    localparam int CNT_W = $clog2(LOCK_FIELDS + 1);
    localparam logic [CNT_W-1:0] LOCK_TOP = CNT_W'(LOCK_FIELDS);

    logic           field_start;
    logic           fid_cand;
    logic           sof_xfer;
    fla_evt_t       evt;
    logic [CNT_W-1:0] lock_cnt;

    fla_field_tracker u_track (
        .clk        (clk),
        .rst        (rst),
        .vt_active  (vt_active),
        .vt_vblank  (vt_vblank),
        .field_start(field_start)
    );

    assign sof_xfer = s_tvalid && s_tready && s_tuser;

    if (FID_DELAY == 0) begin : g_nodelay
        assign fid_cand = s_fid;
    end else begin : g_delay
        fla_fid_delay #(.DEPTH(FID_DELAY)) u_delay (
            .clk     (clk),
            .rst     (rst),
            .fid_in  (s_fid),
            .shift   (sof_xfer),
            .fid_cand(fid_cand)
        );
    end

    fla_align_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .s_tvalid   (s_tvalid),
        .s_tuser    (s_tuser),
        .vt_active  (vt_active),
        .field_start(field_start),
        .fid_match  (fid_cand == vt_fid),
        .s_tready   (s_tready),
        .evt        (evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_cnt <= '0;
        end else if (evt.mism || evt.uflow || evt.lost) begin
            lock_cnt <= '0;
        end else if (evt.aligned && lock_cnt != LOCK_TOP) begin
            lock_cnt <= lock_cnt + 1'b1;
        end
    end

    assign locked = (lock_cnt == LOCK_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            vo_data   <= '0;
            vo_active <= 1'b0;
            vo_eol    <= 1'b0;
            vo_fid    <= 1'b0;
            mismatch  <= 1'b0;
        end else begin
            vo_data   <= evt.take ? s_tdata : '0;
            vo_eol    <= evt.take && s_tlast;
            vo_active <= vt_active;
            vo_fid    <= vt_fid;
            mismatch  <= evt.mism;
        end
    end
endmodule

// File: rtl/field_lock_aligner_chk.sv
module field_lock_aligner_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              s_tvalid,
    input logic              s_tready,
    input logic              s_tuser,
    input logic              vt_active,
    input logic              vt_fid,
    input logic [DATA_W-1:0] vo_data,
    input logic              vo_active,
    input logic              vo_fid,
    input logic              locked,
    input logic              mismatch
);
    // R5
    sof_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_tuser && !vt_active) |-> !s_tready);

    // R6
    mism_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mismatch |=> !mismatch);

    // R7
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(vt_active) && $past(s_tready)));

    // R8
    underflow_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && vt_active && !s_tvalid) |=> !locked);

    // R9
    blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !vo_active |-> (vo_data == '0));

    // R9
    fid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (vo_fid == $past(vt_fid)));
endmodule

bind field_lock_aligner field_lock_aligner_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .s_tuser  (s_tuser),
    .vt_active(vt_active),
    .vt_fid   (vt_fid),
    .vo_data  (vo_data),
    .vo_active(vo_active),
    .vo_fid   (vo_fid),
    .locked   (locked),
    .mismatch (mismatch)
);

// File: tb/field_lock_aligner_tb_top.sv
`timescale 1ns/1ps
module field_lock_aligner_tb_top;
    localparam int DW = 16;
    localparam int D  = 1;
    localparam int W  = 8;
    localparam int H  = 4;
    localparam int HB = 3;
    localparam int VB = 6;
    localparam int NF = 24;

    logic clk = 1'b0;
    logic rst;
    logic [DW-1:0] s_tdata;
    logic s_tvalid, s_tready, s_tuser, s_tlast, s_fid;
    logic vt_active, vt_vblank, vt_fid;
    logic [DW-1:0] vo_data;
    logic vo_active, vo_eol, vo_fid, locked, mismatch;

    always #5 clk = ~clk;

    field_lock_aligner #(.DATA_W(DW), .FID_DELAY(D), .LOCK_FIELDS(2)) dut_i (
        .clk(clk), .rst(rst),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tuser(s_tuser), .s_tlast(s_tlast), .s_fid(s_fid),
        .vt_active(vt_active), .vt_vblank(vt_vblank), .vt_fid(vt_fid),
        .vo_data(vo_data), .vo_active(vo_active), .vo_eol(vo_eol),
        .vo_fid(vo_fid), .locked(locked), .mismatch(mismatch)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    logic fid_tab [NF+2];
    int   sj = 0;
    int   sn = 0;
    int   en = 0;
    int   cnt = 0;
    bit   finished = 1'b0;

    function automatic logic [DW-1:0] pix(input int j, input int n);
        return DW'((j * 37 + n * 11 + 5) ^ (j << 4) ^ (n << 9));
    endfunction

    // compare parity per R4 against generator parity per R3
    function automatic logic field_match(input int k);
        logic eff;
        eff = (k < D) ? 1'b0 : fid_tab[k-D];
        return eff == k[0];
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic act, input logic vb, input int k,
                        input logic fs, input logic stall);
        logic mk, tk, exp_eol, exp_mis, hs;
        logic [DW-1:0] exp_d;
        vt_active = act;
        vt_vblank = vb;
        vt_fid    = k[0];
        s_tvalid  = !stall;
        s_tuser   = (sn == 0);
        s_tlast   = ((sn % W) == W - 1);
        s_tdata   = pix(sj, sn);
        // R2: parity on non-start beats is noise
        s_fid     = (sn == 0) ? fid_tab[sj] : 1'($urandom);
        #1;
        hs = s_tvalid && s_tready;
        if (s_tvalid && s_tuser && !fs)
            chk(s_tready == 1'b0, "R5 ready low with start-of-frame waiting", s_tready, 0);
        mk = field_match(k);
        if (fs) begin
            en  = 0;
            cnt = mk ? ((cnt < 2) ? cnt + 1 : 2) : 0;
        end
        tk      = act && mk && !stall;
        exp_d   = tk ? pix(k, en) : '0;
        exp_eol = tk && ((en % W) == W - 1);
        exp_mis = fs && !mk;
        if (tk) en++;
        if (act && mk && stall) cnt = 0;
        @(posedge clk);
        #1;
        if (!act)
            chk(vo_data == exp_d, "R9 blank data", vo_data, exp_d);
        else if (mk)
            chk(vo_data == exp_d, "R1/R4 released pixel", vo_data, exp_d);
        else
            chk(vo_data == exp_d, "R3/R2 held field", vo_data, exp_d);
        chk(vo_eol == exp_eol, "R1 line end", vo_eol, exp_eol);
        chk(vo_active == act, "R9 active follow", vo_active, act);
        chk(vo_fid == k[0], "R9 parity follow", vo_fid, k[0]);
        chk(mismatch == exp_mis, "R6 mismatch pulse", mismatch, exp_mis);
        if (stall)
            chk(locked == 1'b0, "R8 underflow unlock", locked, 0);
        else
            chk(locked == (cnt == 2), "R7 lock state", locked, (cnt == 2));
        if (hs) begin
            sn++;
            if (sn == W * H) begin
                sn = 0;
                sj++;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int j = 0; j < NF + 2; j++) fid_tab[j] = 1'($urandom);
        fid_tab[0] = 1'b1;   // field 1 aligned -> lock after two starts
        fid_tab[1] = 1'b1;   // field 2 mismatches
        for (int k = NF - 3; k < NF; k++) fid_tab[k-1] = k[0];
        rst = 1'b1;
        s_tvalid = 1'b0; s_tuser = 1'b0; s_tlast = 1'b0; s_fid = 1'b0; s_tdata = '0;
        vt_active = 1'b0; vt_vblank = 1'b0; vt_fid = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(vo_data == '0 && vo_active == 1'b0 && vo_eol == 1'b0, "R10 reset outputs", vo_data, 0);
        chk(locked == 1'b0 && mismatch == 1'b0 && vo_fid == 1'b0, "R10 reset flags", locked, 0);
        rst = 1'b0;
        for (int k = 0; k < NF; k++) begin
            for (int v = 0; v < VB; v++) step(1'b0, 1'b1, k, 1'b0, 1'b0);
            for (int l = 0; l < H; l++) begin
                for (int c = 0; c < W; c++)
                    step(1'b1, 1'b0, k, (l == 0 && c == 0), (k == NF - 1 && l == 1 && c == 3));
                for (int h = 0; h < HB; h++) step(1'b0, 1'b0, k, 1'b0, 1'b0);
            end
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule